// File: doc/BRIEF.md
# Lane Pack and Interleave Permuter

The block rearranges the lanes of two 128-bit operands according to a 4-bit operation code. Its fixed set of lane shuffles includes:

- interleaving the low halves of both operands at byte, halfword or word granularity;
- interleaving their upper words;
- gathering even words;
- broadcasting the lowest halfword of each 64-bit half;
- joining the low or high doublewords of the two operands;
- rotating the three lower words while the top word stays in place.

No arithmetic takes place: every result bit is a copy of one source bit or a zero.

The permutation network is purely combinational. One register stage at the output presents a write request for a register file. The request carries a destination index, the result and an illegal-operation flag. A source index of zero makes that operand read as all zeros. A destination index of zero cancels the write. Codes outside the defined set raise the illegal flag and write nothing. Operand A is the first source and operand B the second. Words, halfwords and bytes are numbered from the least significant end.

Top module: `lane_permuter`

## Requirements
- R1: Codes 0, 1 and 2 interleave the low 64 bits of A and B using 8-, 16- and 32-bit lanes respectively. Result lane 2i holds lane i of B, and result lane 2i+1 holds lane i of A, for i from 0 upward.
- R2: Code 3 returns, from word 0 to word 3: B word 2, A word 2, B word 3, A word 3.
- R3: Code 4 returns, from word 0 to word 3: B word 0, B word 2, A word 0, A word 2.
- R4: Code 5 fills all four halfwords of the result's low 64 bits with B halfword 0. It fills all four halfwords of the high 64 bits with B halfword 4.
- R5: Code 6 places B bits 63:0 in result bits 63:0 and A bits 63:0 in result bits 127:64.
- R6: Code 7 places A bits 127:64 in result bits 63:0 and B bits 127:64 in result bits 127:64.
- R7: Code 8 returns, from word 0 to word 3: B word 1, B word 2, B word 0, B word 3.
- R8: When a source index is zero, that operand is treated as all zeros, whatever value is on its data input.
- R9: An accepted operation with destination index zero produces out_we low, out_dst zero and out_data zero.
- R10: Codes 9 to 15 set out_illegal in the following cycle, keep out_we low and drive out_data to zero.
- R11: Results appear one clock after in_valid. In a cycle after in_valid was low, out_we, out_illegal, out_dst and out_data are all zero.
- R12: While reset is asserted and after it is released, all outputs are zero until the first accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code |
| in_dst | input | 5 | Destination register index |
| in_src_a_idx | input | 5 | Index of first source |
| in_src_b_idx | input | 5 | Index of second source |
| in_src_a | input | 128 | First source data |
| in_src_b | input | 128 | Second source data |
| out_we | output | 1 | Write request |
| out_dst | output | 5 | Destination index of the write |
| out_data | output | 128 | Permuted result |
| out_illegal | output | 1 | Undefined operation code seen |

## Verification
Each defined code is tried with several operand patterns, and each pattern separates a different class of error:

- Two random operands catch swapped A/B roles and wrong lane indices.
- All-ones A against all-zeros B exposes which source feeds each result lane.
- A byte-ramp pattern (byte k holds k) makes a misplaced lane, or the wrong lane width, show up as a wrong byte number.

Undefined codes, zero destinations, zero source indices with non-zero data and idle cycles between operations cover the suppression and gating paths.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ILV_B   = 4'd0,
      OP_ILV_H   = 4'd1,
      OP_ILV_W   = 4'd2,
      OP_ILV_UW  = 4'd3,
      OP_PACK_EW = 4'd4,
      OP_BCAST_H = 4'd5,
      OP_CAT_LO  = 4'd6,
      OP_CAT_HI  = 4'd7,
      OP_ROT3    = 4'd8
   } perm_op_e;

   localparam logic [OP_W-1:0] OP_LAST = OP_ROT3;

   function automatic logic op_is_legal(input logic [OP_W-1:0] op);
      return op <= OP_LAST;
   endfunction

endpackage

// File: rtl/lane_src_gate.sv
module lane_src_gate #(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   // index zero is the hard-wired zero register
   assign dout = (idx == '0) ? '0 : din;
endmodule

// File: rtl/lane_interleave.sv
module lane_interleave #(
   parameter int DATA_W = 128,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] r
);
   localparam int HALF_W = DATA_W / 2;
   localparam int NPAIR  = HALF_W / LANE_W;

   generate
      if (HALF_W % LANE_W != 0) begin : g_bad_lane
         $error("lane_interleave: LANE_W must divide DATA_W/2");
      end
      for (genvar i = 0; i < NPAIR; i++) begin : g_pair
         assign r[(2*i)*LANE_W   +: LANE_W] = b[i*LANE_W +: LANE_W];
         assign r[(2*i+1)*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W];
      end
   endgenerate
endmodule

// File: rtl/lane_word_route.sv
module lane_word_route
   import lane_perm_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] r
);
   localparam int W  = DATA_W / 4;
   localparam int H  = DATA_W / 2;
   localparam int HW = DATA_W / 8;

   logic [W-1:0] aw [4];
   logic [W-1:0] bw [4];

   generate
      for (genvar j = 0; j < 4; j++) begin : g_split
         assign aw[j] = a[j*W +: W];
         assign bw[j] = b[j*W +: W];
      end
   endgenerate

   always_comb begin
      r = '0;
      case (op)
         OP_ILV_UW:  r = {aw[3], bw[3], aw[2], bw[2]};
         OP_PACK_EW: r = {aw[2], aw[0], bw[2], bw[0]};
         OP_BCAST_H: r = {{4{b[H +: HW]}}, {4{b[0 +: HW]}}};
         OP_CAT_LO:  r = {a[H-1:0], b[H-1:0]};
         OP_CAT_HI:  r = {b[DATA_W-1:H], a[DATA_W-1:H]};
         OP_ROT3:    r = {bw[3], bw[0], bw[2], bw[1]};
         default:    r = '0;
      endcase
   end
endmodule

// File: rtl/lane_permuter.sv
module lane_permuter
   import lane_perm_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [IDX_W-1:0]  in_dst,
   input  logic [IDX_W-1:0]  in_src_a_idx,
   input  logic [IDX_W-1:0]  in_src_b_idx,
   input  logic [DATA_W-1:0] in_src_a,
   input  logic [DATA_W-1:0] in_src_b,
   output logic              out_we,
   output logic [IDX_W-1:0]  out_dst,
   output logic [DATA_W-1:0] out_data,
   output logic              out_illegal
);
   localparam int N_ILV = 3;

   generate
      if (DATA_W < 16 || DATA_W % 16 != 0) begin : g_bad_width
         $error("lane_permuter: DATA_W must be a positive multiple of 16");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("lane_permuter: IDX_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] ga, gb;
   logic [DATA_W-1:0] ilv_r [N_ILV];
   logic [DATA_W-1:0] word_r;
   logic [DATA_W-1:0] result;
   logic              legal, we_d;

   lane_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_a (
      .idx(in_src_a_idx), .din(in_src_a), .dout(ga));
   lane_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_b (
      .idx(in_src_b_idx), .din(in_src_b), .dout(gb));

   // interleavers at byte, halfword and word lanes
   generate
      for (genvar g = 0; g < N_ILV; g++) begin : g_ilv
         lane_interleave #(.DATA_W(DATA_W), .LANE_W(DATA_W >> (4 - g))) u_ilv (
            .a(ga), .b(gb), .r(ilv_r[g]));
      end
   endgenerate

   lane_word_route #(.DATA_W(DATA_W)) u_route (
      .op(in_op), .a(ga), .b(gb), .r(word_r));

   always_comb begin
      case (in_op)
         OP_ILV_B: result = ilv_r[0];
         OP_ILV_H: result = ilv_r[1];
         OP_ILV_W: result = ilv_r[2];
         default:  result = word_r;
      endcase
   end

   assign legal = op_is_legal(in_op);
   assign we_d  = in_valid && legal && (in_dst != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_we      <= 1'b0;
         out_dst     <= '0;
         out_data    <= '0;
         out_illegal <= 1'b0;
      end else begin
         out_we      <= we_d;
         out_dst     <= we_d ? in_dst : '0;
         out_data    <= we_d ? result : '0;
         out_illegal <= in_valid && !legal;
      end
   end
endmodule

// File: rtl/lane_permuter_chk.sv
module lane_permuter_chk #(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        in_op,
   input logic [IDX_W-1:0]  in_dst,
   input logic [IDX_W-1:0]  in_src_a_idx,
   input logic [IDX_W-1:0]  in_src_b_idx,
   input logic [DATA_W-1:0] in_src_a,
   input logic [DATA_W-1:0] in_src_b,
   input logic              out_we,
   input logic [IDX_W-1:0]  out_dst,
   input logic [DATA_W-1:0] out_data,
   input logic              out_illegal
);
   localparam int H = DATA_W / 2;
   localparam int W = DATA_W / 4;

   logic [DATA_W-1:0] za, zb;
   assign za = (in_src_a_idx == '0) ? '0 : in_src_a;
   assign zb = (in_src_b_idx == '0) ? '0 : in_src_b;

   p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dst == '0) |=> !out_we);

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_we |-> (out_data == '0 && out_dst == '0));

   p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op > 4'd8) |=> (out_illegal && !out_we && out_data == '0));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_we && !out_illegal));

   p_cat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 4'd6 && in_dst != '0) |=>
      out_data == {$past(za[H-1:0]), $past(zb[H-1:0])});

   p_rot3_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 4'd8 && in_dst != '0) |=>
      (out_data[DATA_W-1 -: W] == $past(zb[DATA_W-1 -: W]) &&
       out_data[W-1:0] == $past(zb[2*W-1:W])));

   p_zero_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 4'd6 && in_dst != '0 &&
       in_src_a_idx == '0 && in_src_b_idx == '0) |=> out_data == '0);
endmodule

bind lane_permuter lane_permuter_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/lane_permuter_tb.sv
`timescale 1ns/100ps
module lane_permuter_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   in_op = '0;
   logic [4:0]   in_dst = '0, in_src_a_idx = '0, in_src_b_idx = '0;
   logic [127:0] in_src_a = '0, in_src_b = '0;
   logic         out_we, out_illegal;
   logic [4:0]   out_dst;
   logic [127:0] out_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic         e_we, e_ill;
   logic [4:0]   e_dst;
   logic [127:0] e_data;

   always #2.5 clk = ~clk;

   lane_permuter u_dut (.*);

   function automatic logic [31:0] wd(logic [127:0] v, int j);
      return v[32*j +: 32];
   endfunction

   function automatic logic [127:0] model(int op, logic [127:0] a, logic [127:0] b);
      logic [127:0] r = '0;
      if (op <= 2) begin
         int w = 8 << op;
         for (int i = 0; i < 64 / w; i++)
            for (int k = 0; k < w; k++) begin
               r[2*i*w + k]     = b[i*w + k];
               r[(2*i+1)*w + k] = a[i*w + k];
            end
      end else if (op == 3) r = {wd(a,3), wd(b,3), wd(a,2), wd(b,2)};
      else if (op == 4) r = {wd(a,2), wd(a,0), wd(b,2), wd(b,0)};
      else if (op == 5) begin
         for (int k = 0; k < 64; k++) begin
            r[k]      = b[k % 16];
            r[64 + k] = b[64 + (k % 16)];
         end
      end
      else if (op == 6) r = {a[63:0], b[63:0]};
      else if (op == 7) r = {b[127:64], a[127:64]};
      else if (op == 8) r = {wd(b,3), wd(b,0), wd(b,2), wd(b,1)};
      return r;
   endfunction

   task automatic compare(string tag);
      n_checks++;
      if (out_we !== e_we || out_illegal !== e_ill || out_dst !== e_dst || out_data !== e_data) begin
         n_fail++;
         $display("FAIL %s: got we=%b ill=%b dst=%0d data=%h, expected we=%b ill=%b dst=%0d data=%h",
                  tag, out_we, out_illegal, out_dst, out_data, e_we, e_ill, e_dst, e_data);
      end
   endtask

   // called at a falling edge; result checked at the next falling edge
   task automatic step(string tag, int op, int dst, int ia, int ib,
                       logic [127:0] a, logic [127:0] b);
      logic [127:0] ga = (ia == 0) ? '0 : a;
      logic [127:0] gb = (ib == 0) ? '0 : b;
      in_valid = 1'b1; in_op = op[3:0]; in_dst = dst[4:0];
      in_src_a_idx = ia[4:0]; in_src_b_idx = ib[4:0];
      in_src_a = a; in_src_b = b;
      e_ill  = (op > 8);
      e_we   = !e_ill && dst != 0;
      e_dst  = e_we ? dst[4:0] : '0;
      e_data = e_we ? model(op, ga, gb) : '0;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(string tag);
      in_valid = 1'b0;
      in_src_a = {4{$urandom}}; in_src_b = {4{$urandom}};
      in_op = 4'd6; in_dst = 5'd7;
      e_we = 0; e_ill = 0; e_dst = '0; e_data = '0;
      @(negedge clk);
      compare(tag);
   endtask

   function automatic string op_tag(int op);
      case (op)
         0, 1, 2: return "R1";
         3: return "R2";
         4: return "R3";
         5: return "R4";
         6: return "R5";
         7: return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      logic [127:0] ramp;
      for (int k = 0; k < 16; k++) ramp[8*k +: 8] = k[7:0];
      e_we = 0; e_ill = 0; e_dst = '0; e_data = '0;
      repeat (3) @(negedge clk);
      compare("R12");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R12");

      for (int op = 0; op <= 8; op++) begin
         step(op_tag(op), op, 3, 1, 2, {$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom});
         step(op_tag(op), op, 9, 4, 5, '1, '0);
         step(op_tag(op), op, 31, 6, 7, ramp, ~ramp);
         step(op_tag(op), op, 1, 8, 8, ramp, {ramp[63:0], ramp[127:64]});
      end
      for (int op = 0; op <= 8; op++) begin
         step("R8", op, 2, 0, 3, '1, ramp);
         step("R8", op, 2, 3, 0, ramp, '1);
      end
      for (int op = 9; op <= 15; op++) step("R10", op, 4, 1, 2, ramp, '1);
      for (int op = 0; op <= 8; op++) step("R9", op, 0, 1, 2, ramp, '1);
      idle("R11");
      step("R5", 6, 12, 1, 2, '1, ramp);
      idle("R11");
      idle("R11");
      step("R10", 15, 0, 1, 2, ramp, ramp);
      step("R7", 8, 5, 1, 2, ramp, ramp);
      idle("R11");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule